// File: doc/BRIEF.md
# Shadow Routing Table Swap Controller

This block manages a double-buffered routing memory for a time-division-multiplexed serial port. Each of four routing channels (receive and transmit for TDM a and for TDM b) owns two halves of the memory. One half is the live table that the serial engine reads. The other half is a spare that software may rewrite at any time. Software fills the spare half and then sets a request bit in an 8-bit command register. The block holds that request until the next frame boundary of the matching channel. At that boundary it swaps the two halves, so that no frame is ever routed from a mix of old and new entries.

An 8-bit status register shows which half is live for each channel. A per-channel base-address output gives the first entry of the live half to the routing logic. A 2-bit division-mode input selects how the memory is partitioned. In one-TDM mode only the TDM a channels are active, and each half spans half the memory. In two-TDM mode all four channels are active, and each half spans a quarter of the memory. The two remaining codes disable the block.

Top module: `shadowRouteSwap`

## Requirements
- R1: While reset is asserted and just after it, both registers read 0x00 and every base output is 0.
- R2: A write with regAddr=0 loads command bits 7:4, and reading regAddr=0 returns them. Bit 7 is receive TDM a, bit 6 transmit TDM a, bit 5 receive TDM b and bit 4 transmit TDM b.
- R3: Bits 3:0 of both registers always read 0, whatever value was written.
- R4: A pending request stays set until a pulse on frameSync for its channel. frameSync[3] is receive a, [2] transmit a, [1] receive b and [0] transmit b, matching command bits 7..4. On the edge where the pulse is sampled, the status bit toggles and the command bit clears.
- R5: A frameSync pulse on a channel with no pending request leaves its status bit unchanged.
- R6: Status bits are read-only. A write with regAddr=1 changes no state.
- R7: In one-TDM mode (divMode=01), a TDM a channel's base is 64 when its status bit is 1 and 0 when it is 0. TDM b requests are dropped, and the TDM b bases are 0.
- R8: In two-TDM mode (divMode=11), every channel's base is 32 when its status bit is 1 and 0 when it is 0.
- R9: In divMode 00 or 10, command writes are ignored and any pending request is cleared. The command register reads 0, status does not move, and all bases are 0.
- R10: If a command write and a frameSync pulse fall in the same cycle, the swap uses the request that was pending before the write, and the written value is what remains pending afterwards.
- R11: A swap on one channel leaves the command and status bits of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divMode | input | 2 | Memory division mode: 01 one TDM, 11 two TDMs, other codes disabled |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 command, 1 status |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data of the selected register |
| frameSync | input | 4 | Per-channel frame boundary pulse |
| routeBase | output | 28 | Live-half base entry, 7 bits per channel, channel i at [7i+6:7i] |

## Verification
The embedded assertions check four things on every cycle. Status moves only when a swap strobe fires, and then by exactly the strobed bits. A swap without a simultaneous write leaves the swapped command bits clear. A disabled mode leaves no pending request one cycle later. A two-TDM base only ever takes one of its two legal values. The bench scenarios cover the rest. They show that a request waits through several idle frames, and that the written bit positions map onto the right channels. They also show the same-cycle write and swap case, the dropping of TDM b requests in one-TDM mode, and the base values seen at the port in each mode.

// File: rtl/routeSwapPkg.sv
package routeSwapPkg;
  localparam int NUM_CH = 4;

  typedef enum logic [1:0] {
    PART_NONE = 2'd0,
    PART_ONE  = 2'd1,
    PART_TWO  = 2'd2
  } partMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] swap;      // exchange live and spare half now
    logic              load;      // command register write
    logic [NUM_CH-1:0] loadVal;   // masked write value
    logic [NUM_CH-1:0] keepMask;  // channels active in current mode
    partMode_e         part;
  } swapStrobe_t;
endpackage

// File: rtl/routeSwapCtrl.sv
module routeSwapCtrl
  import routeSwapPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        divMode,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [7:0]        regWrData,
  input  logic [NUM_CH-1:0] frameSync,
  input  logic [NUM_CH-1:0] cmdQ,
  output swapStrobe_t       strb
);
  partMode_e         part;
  logic [NUM_CH-1:0] chanEn;
  logic              unusedLowBits;

  assign unusedLowBits = ^regWrData[3:0];

  always_comb begin
    unique case (divMode)
      2'b01:   part = PART_ONE;
      2'b11:   part = PART_TWO;
      default: part = PART_NONE;
    endcase
  end

  // TDM a channels occupy the upper indices
  for (genvar i = 0; i < NUM_CH; i++) begin : g_en
    assign chanEn[i] = (part == PART_TWO) ||
                       ((part == PART_ONE) && (i >= NUM_CH/2));
  end

  always_comb begin
    strb.swap     = cmdQ & frameSync & chanEn;
    strb.load     = regWrEn && !regAddr;
    strb.loadVal  = regWrData[4 +: NUM_CH] & chanEn;
    strb.keepMask = chanEn;
    strb.part     = part;
  end

  // R9: a disabled mode leaves nothing pending on the next cycle
  p_disabled_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    (part == PART_NONE) |=> (cmdQ == '0));
endmodule

// File: rtl/routeSwapData.sv
module routeSwapData
  import routeSwapPkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int ADDR_W = $clog2(ENTRIES)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  swapStrobe_t              strb,
  input  logic                     regAddr,
  output logic [NUM_CH-1:0]        cmdQ,
  output logic [7:0]               regRdData,
  output logic [NUM_CH*ADDR_W-1:0] routeBase
);
  localparam logic [ADDR_W-1:0] HALF_ONE = ADDR_W'(ENTRIES/2);
  localparam logic [ADDR_W-1:0] HALF_TWO = ADDR_W'(ENTRIES/4);

  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] cmdNext;
  logic [ADDR_W-1:0] halfSize;

  always_comb begin
    if (strb.load) cmdNext = strb.loadVal;
    else           cmdNext = cmdQ & ~strb.swap;
    cmdNext = cmdNext & strb.keepMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ    <= '0;
      statusQ <= '0;
    end else begin
      cmdQ    <= cmdNext;
      statusQ <= statusQ ^ strb.swap;
    end
  end

  assign regRdData = regAddr ? {statusQ, 4'h0} : {cmdQ, 4'h0};
  assign halfSize  = (strb.part == PART_ONE) ? HALF_ONE : HALF_TWO;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_base
    assign routeBase[i*ADDR_W +: ADDR_W] =
      (strb.keepMask[i] && statusQ[i]) ? halfSize : '0;

    // R8: two-TDM base is one of the two quarter boundaries
    p_base_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
      (strb.part == PART_TWO) |->
        (routeBase[i*ADDR_W +: ADDR_W] == '0 ||
         routeBase[i*ADDR_W +: ADDR_W] == HALF_TWO));
  end

  // R5: no swap strobe, no status movement
  p_status_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.swap == '0) |=> $stable(statusQ));

  // R4: a swap flips exactly the strobed channels
  p_swap_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.swap != '0) |=> (statusQ == ($past(statusQ) ^ $past(strb.swap))));

  // R4: swapped requests are consumed unless rewritten in the same cycle
  p_swap_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.swap != '0 && !strb.load) |=> ((cmdQ & $past(strb.swap)) == '0));
endmodule

// File: rtl/shadowRouteSwap.sv
module shadowRouteSwap
  import routeSwapPkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int ADDR_W = $clog2(ENTRIES)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               divMode,
  input  logic                     regWrEn,
  input  logic                     regAddr,
  input  logic [7:0]               regWrData,
  output logic [7:0]               regRdData,
  input  logic [NUM_CH-1:0]        frameSync,
  output logic [NUM_CH*ADDR_W-1:0] routeBase
);
  swapStrobe_t       strb;
  logic [NUM_CH-1:0] cmdQ;

  routeSwapCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .divMode(divMode), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .frameSync(frameSync),
    .cmdQ(cmdQ), .strb(strb)
  );

  routeSwapData #(.ENTRIES(ENTRIES)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .cmdQ(cmdQ), .regRdData(regRdData), .routeBase(routeBase)
  );
endmodule

// File: tb/test_shadowRouteSwap.sv
`timescale 1ns/100ps
module test_shadowRouteSwap;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  divMode = 2'b11;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic [3:0]  frameSync = 4'h0;
  logic [27:0] routeBase;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shadowRouteSwap i_shadowRouteSwap (
    .clk(clk), .rstN(rstN), .divMode(divMode), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .frameSync(frameSync), .routeBase(routeBase)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       wr;
    logic       addr;
    logic [7:0] data;
    logic [3:0] fs;
    logic [3:0] expCmd;
    logic [3:0] expSt;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b1, 1'b0, 8'h8F, 4'h0, 4'h8, 4'h0, 8'd2},  // R2 R3 load rx a
    '{2'd3, 1'b0, 1'b0, 8'h00, 4'h4, 4'h8, 4'h0, 8'd5},  // R5 sync on idle ch
    '{2'd3, 1'b0, 1'b0, 8'h00, 4'h8, 4'h0, 4'h8, 8'd4},  // R4 swap rx a
    '{2'd3, 1'b1, 1'b0, 8'h70, 4'h0, 4'h7, 4'h8, 8'd2},  // R2 three requests
    '{2'd3, 1'b0, 1'b0, 8'h00, 4'h2, 4'h5, 4'hA, 8'd11}, // R11 swap rx b only
    '{2'd3, 1'b1, 1'b1, 8'hF0, 4'h0, 4'h5, 4'hA, 8'd6},  // R6 status write
    '{2'd3, 1'b1, 1'b0, 8'h8F, 4'h5, 4'h8, 4'hF, 8'd10}, // R10 write + sync
    '{2'd3, 1'b0, 1'b0, 8'h00, 4'hF, 4'h0, 4'h7, 8'd4},  // R4 swap rx a back
    '{2'd1, 1'b1, 1'b0, 8'hF0, 4'h0, 4'hC, 4'h7, 8'd7},  // R7 b dropped
    '{2'd1, 1'b0, 1'b0, 8'h00, 4'hF, 4'h0, 4'hB, 8'd7},  // R7 swap a only
    '{2'd0, 1'b1, 1'b0, 8'hF0, 4'h0, 4'h0, 4'hB, 8'd9},  // R9 write ignored
    '{2'd3, 1'b1, 1'b0, 8'h40, 4'h0, 4'h4, 4'hB, 8'd8},  // R8 pending tx a
    '{2'd2, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 4'hB, 8'd9},  // R9 flush
    '{2'd2, 1'b0, 1'b0, 8'h00, 4'hF, 4'h0, 4'hB, 8'd9}   // R9 status frozen
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] expBase(input logic [1:0] m,
                                         input logic [3:0] st, input int i);
    if (m == 2'b11) return st[i] ? 7'd32 : 7'd0;   // R8
    if (m == 2'b01 && i >= 2) return st[i] ? 7'd64 : 7'd0;  // R7
    return 7'd0;
  endfunction

  // reads both registers combinationally and checks all bases
  task automatic readAll(input logic [3:0] eCmd, input logic [3:0] eSt,
                         input int req);
    regAddr = 1'b0;
    #0.4;
    check(regRdData == {eCmd, 4'h0}, req, "command", regRdData, {eCmd, 4'h0});
    regAddr = 1'b1;
    #0.4;
    check(regRdData == {eSt, 4'h0}, req, "status", regRdData, {eSt, 4'h0});
    for (int i = 0; i < 4; i++)
      check(routeBase[i*7 +: 7] == expBase(divMode, eSt, i), req, "base",
            routeBase[i*7 +: 7], expBase(divMode, eSt, i));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    readAll(4'h0, 4'h0, 1);  // R1 during reset
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #0.5;
    readAll(4'h0, 4'h0, 1);  // R1 after release

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      divMode   = VECS[v].mode;
      regWrEn   = VECS[v].wr;
      regAddr   = VECS[v].addr;
      regWrData = VECS[v].data;
      frameSync = VECS[v].fs;
      @(posedge clk);
      #0.5;
      regWrEn   = 1'b0;
      frameSync = 4'h0;
      readAll(VECS[v].expCmd, VECS[v].expSt, int'(VECS[v].req));
    end

    // R4: request waits through idle frames
    @(negedge clk);
    divMode = 2'b11; regWrEn = 1'b1; regAddr = 1'b0; regWrData = 8'hF0;
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (5) @(negedge clk);
    readAll(4'hF, 4'hB, 4);
    // R11: swap on tx b leaves others pending
    frameSync = 4'h1;
    @(posedge clk);
    #0.5;
    frameSync = 4'h0;
    readAll(4'hE, 4'hA, 11);
    // R3: reserved low bits on both registers stay zero
    @(negedge clk);
    regAddr = 1'b0;
    check(regRdData[3:0] == 4'h0, 3, "low bits", regRdData, 8'h00);

    // R1: reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    #0.5;
    readAll(4'h0, 4'h0, 1);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule